// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block watches four comparator match lines and walks a debug trigger through three intermediate states until it reaches a final state. When it reaches that state, it fires a one-cycle trigger pulse. Each intermediate state has its own 4-bit routing code. The code names the match channels that matter in that state and the state that each of them leads to. Matches that the code does not name are ignored, and the sequencer stays where it is.

Software programs the block before it starts. It writes the three routing codes and a comparator-enable mask through a small write/read port, then raises an arm request. The sequencer runs from State1 until a routed match reaches the final state or a disarm request returns it to idle. The configuration is locked while the sequencer is armed, and it stays readable at all times.

Top module: `trig_seq_top`

## Requirements
- R1: After reset, state_o is 0 (idle), armed_o and trig_o are 0, and all four configuration registers read back as 0.
- R2: An arm request while unarmed, with no disarm in the same cycle, moves state_o to 1 (State1) and sets armed_o at the next clock edge. This works from both idle and final. An arm request while armed has no effect.
- R3: A disarm request moves state_o to 0 and clears armed_o at the next edge, whatever the state. It overrides any arm request and any match in the same cycle.
- R4: A match counts only when its bit in the enable register (address 3, bit n for channel n) is 1. A match with a clear enable bit leaves state_o unchanged.
- R5: Each intermediate state has two alternative targets, A and B: State1 uses A=2 and B=3, State2 uses A=1 and B=3, and State3 uses A=1 and B=2. Final is state 4. The routing codes are:
  - 1: m0 leads to A.
  - 2: m1 leads to A.
  - 3: m0 leads to B.
  - 4: m1 leads to B.
  - 5: m2 leads to B.
  - 6: m1 leads to A and m3 leads to B.
  - 7: m0 leads to Final.
  - 8: m1 leads to Final.
  - 9: m2 leads to Final.
  - 10: m3 leads to Final.
  - 11: any match leads to Final.
  - 12: any match leads to A.
  - 13: any match leads to B.
  - 14: m2 leads to Final and m0 leads to B.
  - 15: m3 leads to Final and m1 leads to A.
- R6: When matches arrive in the same cycle, a named match that leads to Final wins over any other named match, including one on a lower channel.
- R7: When no named match leads to Final, the named match on the lowest channel number selects the next state.
- R8: Code 0 is reserved and causes no transition. A match that the current code does not name has no effect, and the state is held.
- R9: On entry to Final, trig_o is high for exactly one cycle and armed_o clears. The sequencer then stays in Final, ignoring all matches, until it is armed again.
- R10: A write (address 0, 1 or 2 for the State1, State2 and State3 codes, and 3 for the enable mask) takes effect only while armed_o is 0. Reads of cfg_raddr_i are combinational and always available.
- R11: Only the code of the current state is used to route matches. The codes of the other two states play no part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm request |
| disarm_i | input | 1 | Disarm request, wins over arm |
| match_i | input | 4 | Comparator match events, channel n on bit n |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Write address |
| cfg_wdata_i | input | 4 | Write data |
| cfg_raddr_i | input | 2 | Read address |
| cfg_rdata_o | output | 4 | Read data for cfg_raddr_i |
| state_o | output | 3 | 0 idle, 1 State1, 2 State2, 3 State3, 4 Final |
| armed_o | output | 1 | Sequencer armed |
| trig_o | output | 1 | One-cycle pulse on entry to Final |

## Verification
The hardest case to reach is a contest between simultaneous matches deep in the sequence, for example a Final-bound match on channel 3 against a lower-channel match bound elsewhere while in State2. The sequencer has to be led there through earlier routed matches. The codes cannot change once armed, so all three codes and the enable mask are written before arming, and a directed walk drives single matches through State1, State3 and State2 before presenting the contested pair. A long stretch of random arms, disarms, unarmed writes and match patterns then runs against a behavioural model that is compared every cycle.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int unsigned N_CH   = 4;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned N_SEQ  = 3;
  localparam int unsigned N_REG  = N_SEQ + 1;
  localparam int unsigned ADDR_W = $clog2(N_REG);
  localparam int unsigned ST_W   = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FINAL = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    GO_NONE,
    GO_ALT_A,
    GO_ALT_B,
    GO_FINAL
  } go_e;

  // route taken by one channel under a given code
  function automatic go_e code_route(input logic [CODE_W-1:0] code, input int ch);
    go_e r;
    r = GO_NONE;
    case (code)
      4'd1:  if (ch == 0) r = GO_ALT_A;
      4'd2:  if (ch == 1) r = GO_ALT_A;
      4'd3:  if (ch == 0) r = GO_ALT_B;
      4'd4:  if (ch == 1) r = GO_ALT_B;
      4'd5:  if (ch == 2) r = GO_ALT_B;
      4'd6:  if (ch == 1) r = GO_ALT_A; else if (ch == 3) r = GO_ALT_B;
      4'd7:  if (ch == 0) r = GO_FINAL;
      4'd8:  if (ch == 1) r = GO_FINAL;
      4'd9:  if (ch == 2) r = GO_FINAL;
      4'd10: if (ch == 3) r = GO_FINAL;
      4'd11: r = GO_FINAL;
      4'd12: r = GO_ALT_A;
      4'd13: r = GO_ALT_B;
      4'd14: if (ch == 2) r = GO_FINAL; else if (ch == 0) r = GO_ALT_B;
      4'd15: if (ch == 3) r = GO_FINAL; else if (ch == 1) r = GO_ALT_A;
      default: r = GO_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
  import trig_seq_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          armed_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             waddr_i,
  input  logic [CODE_W-1:0]             wdata_i,
  input  logic [ADDR_W-1:0]             raddr_i,
  output logic [CODE_W-1:0]             rdata_o,
  output logic [N_SEQ-1:0][CODE_W-1:0]  code_o,
  output logic [N_CH-1:0]               en_o
);
  logic [N_REG-1:0][CODE_W-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else if (we_i && !armed_i) regs_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < N_SEQ; g++) begin : g_code
    assign code_o[g] = regs_q[g];
  end
  assign en_o    = N_CH'(regs_q[N_REG-1]);
  assign rdata_o = regs_q[raddr_i];

  assert_cfg_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |=> $stable(regs_q));
endmodule

// File: rtl/trig_seq_route.sv
module trig_seq_route
  import trig_seq_pkg::*;
#(
  parameter int HOME = 1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [N_CH-1:0]   hit_i,
  output logic              fin_o,
  output logic              step_o,
  output logic [ST_W-1:0]   nxt_o
);
  localparam logic [ST_W-1:0] ALT_A = (HOME == 1) ? ST_TWO : ST_ONE;
  localparam logic [ST_W-1:0] ALT_B = (HOME == 3) ? ST_TWO : ST_THREE;

  go_e route [N_CH];

  always_comb begin
    for (int c = 0; c < N_CH; c++) route[c] = code_route(code_i, c);
  end

  always_comb begin
    fin_o  = 1'b0;
    step_o = 1'b0;
    nxt_o  = '0;
    // walk downward so the lowest channel is written last
    for (int c = N_CH - 1; c >= 0; c--) begin
      if (hit_i[c] && (route[c] == GO_ALT_A || route[c] == GO_ALT_B)) begin
        step_o = 1'b1;
        nxt_o  = (route[c] == GO_ALT_A) ? ALT_A : ALT_B;
      end
    end
    for (int c = 0; c < N_CH; c++) begin
      if (hit_i[c] && route[c] == GO_FINAL) fin_o = 1'b1;
    end
  end
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        arm_i,
  input  logic                        disarm_i,
  input  logic [N_SEQ-1:0]            fin_i,
  input  logic [N_SEQ-1:0]            step_i,
  input  logic [N_SEQ-1:0][ST_W-1:0]  nxt_i,
  output logic [ST_W-1:0]             state_o,
  output logic                        armed_o,
  output logic                        trig_o
);
  seq_state_e      state_q, state_d;
  logic            armed_q, armed_d, trig_q, trig_d;
  logic            cur_fin, cur_step;
  logic [ST_W-1:0] cur_nxt;

  always_comb begin
    cur_fin  = 1'b0;
    cur_step = 1'b0;
    cur_nxt  = '0;
    case (state_q)
      ST_ONE:   begin cur_fin = fin_i[0]; cur_step = step_i[0]; cur_nxt = nxt_i[0]; end
      ST_TWO:   begin cur_fin = fin_i[1]; cur_step = step_i[1]; cur_nxt = nxt_i[1]; end
      ST_THREE: begin cur_fin = fin_i[2]; cur_step = step_i[2]; cur_nxt = nxt_i[2]; end
      default:  ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    trig_d  = 1'b0;
    if (disarm_i) begin
      state_d = ST_IDLE;
      armed_d = 1'b0;
    end else if (arm_i && !armed_q) begin
      state_d = ST_ONE;
      armed_d = 1'b1;
    end else if (armed_q) begin
      if (cur_fin) begin
        state_d = ST_FINAL;
        armed_d = 1'b0;
        trig_d  = 1'b1;
      end else if (cur_step) begin
        state_d = seq_state_e'(cur_nxt);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      trig_q  <= trig_d;
    end
  end

  assign state_o = state_q;
  assign armed_o = armed_q;
  assign trig_o  = trig_q;

  assert_disarm_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> (state_q == ST_IDLE && !armed_q));
  assert_arm_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !disarm_i && !armed_q) |=> (state_q == ST_ONE && armed_q));
  assert_trig_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_q |-> (state_q == ST_FINAL && !armed_q));
  assert_final_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FINAL && !arm_i && !disarm_i) |=> (state_q == ST_FINAL && !trig_q));
  assert_unrouted_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !cur_fin && !cur_step && !disarm_i) |=> $stable(state_q));
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
  import trig_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic [N_CH-1:0]   match_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CODE_W-1:0] cfg_wdata_i,
  input  logic [ADDR_W-1:0] cfg_raddr_i,
  output logic [CODE_W-1:0] cfg_rdata_o,
  output logic [ST_W-1:0]   state_o,
  output logic              armed_o,
  output logic              trig_o
);
  logic [N_SEQ-1:0][CODE_W-1:0] code;
  logic [N_CH-1:0]              en, hit;
  logic [N_SEQ-1:0]             fin, step;
  logic [N_SEQ-1:0][ST_W-1:0]   nxt;

  trig_seq_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .armed_i (armed_o),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .raddr_i (cfg_raddr_i),
    .rdata_o (cfg_rdata_o),
    .code_o  (code),
    .en_o    (en)
  );

  assign hit = match_i & en;

  for (genvar g = 0; g < N_SEQ; g++) begin : g_route
    trig_seq_route #(.HOME(g + 1)) u_route (
      .code_i (code[g]),
      .hit_i  (hit),
      .fin_o  (fin[g]),
      .step_o (step[g]),
      .nxt_o  (nxt[g])
    );
  end

  trig_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_i),
    .disarm_i (disarm_i),
    .fin_i    (fin),
    .step_i   (step),
    .nxt_i    (nxt),
    .state_o  (state_o),
    .armed_o  (armed_o),
    .trig_o   (trig_o)
  );
endmodule

// File: tb/trig_seq_top_test.sv
module trig_seq_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 1'b0, disarm = 1'b0, we = 1'b0;
  logic [3:0] match = '0, wdata = '0;
  logic [1:0] waddr = '0, raddr = '0;
  logic [3:0] rdata;
  logic [2:0] state;
  logic       armed, trig;

  int    n_chk = 0, n_err = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  int m_state = 0, m_armed = 0, m_trig = 0;
  int m_reg [4] = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  trig_seq_top uut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .disarm_i(disarm), .match_i(match),
    .cfg_we_i(we), .cfg_addr_i(waddr), .cfg_wdata_i(wdata), .cfg_raddr_i(raddr),
    .cfg_rdata_o(rdata), .state_o(state), .armed_o(armed), .trig_o(trig)
  );

  // next state number for a routing code, 0 when nothing moves
  function automatic int ref_pick(int home, int code, logic [3:0] hit);
    int a, b, any_dst, cx, dx, cy, dy;
    a = (home == 1) ? 2 : 1;
    b = (home == 3) ? 2 : 3;
    any_dst = 0; cx = -1; dx = 0; cy = -1; dy = 0;
    case (code)
      1: begin cx = 0; dx = a; end
      2: begin cx = 1; dx = a; end
      3: begin cx = 0; dx = b; end
      4: begin cx = 1; dx = b; end
      5: begin cx = 2; dx = b; end
      6: begin cx = 1; dx = a; cy = 3; dy = b; end
      7: begin cx = 0; dx = 4; end
      8: begin cx = 1; dx = 4; end
      9: begin cx = 2; dx = 4; end
      10: begin cx = 3; dx = 4; end
      11: any_dst = 4;
      12: any_dst = a;
      13: any_dst = b;
      14: begin cx = 2; dx = 4; cy = 0; dy = b; end
      15: begin cx = 3; dx = 4; cy = 1; dy = a; end
      default: ;
    endcase
    if (any_dst != 0) return (hit != 0) ? any_dst : 0;
    if (cx >= 0 && dx == 4 && hit[cx]) return 4;
    if (cy >= 0 && dy == 4 && hit[cy]) return 4;
    if (cx >= 0 && cy >= 0 && hit[cx] && hit[cy]) return (cx < cy) ? dx : dy;
    if (cx >= 0 && hit[cx]) return dx;
    if (cy >= 0 && hit[cy]) return dy;
    return 0;
  endfunction

  task automatic model_step();
    int old_armed, d;
    old_armed = m_armed;
    m_trig = 0;
    if (disarm) begin
      m_state = 0; m_armed = 0;
    end else if (arm && m_armed == 0) begin
      m_state = 1; m_armed = 1;
    end else if (m_armed != 0) begin
      d = ref_pick(m_state, m_reg[m_state-1], match & m_reg[3][3:0]);
      if (d == 4) begin m_state = 4; m_armed = 0; m_trig = 1; end
      else if (d != 0) m_state = d;
    end
    if (we && old_armed == 0) m_reg[waddr] = wdata;
  endtask

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("state_o", 8'(state), 8'(m_state));
    chk("armed_o", 8'(armed), 8'(m_armed));
    chk("trig_o", 8'(trig), 8'(m_trig));
    chk("cfg_rdata_o", 8'(rdata), 8'(m_reg[raddr]));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    we = 1'b1; waddr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic pulse_arm();
    arm = 1'b1; tick(); arm = 1'b0;
  endtask

  task automatic hit(input logic [3:0] m);
    match = m; tick(); match = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL %s watchdog actual=timeout expected=finish", cur_req);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1 reset values
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin raddr = 2'(a); tick(); end

    // R10 writes while unarmed, read back
    cur_req = "R10";
    wr(2'd0, 4'd13); wr(2'd1, 4'd15); wr(2'd2, 4'd6); wr(2'd3, 4'hF);
    for (int a = 0; a < 4; a++) begin raddr = 2'(a); tick(); end

    cur_req = "R2";
    pulse_arm();
    cur_req = "R10";                 // locked while armed
    wr(2'd0, 4'd0); raddr = 2'd0; tick();
    cur_req = "R2";                  // arm while armed ignored
    pulse_arm();

    cur_req = "R11";                 // State1 code 13: m2 -> State3
    hit(4'b0100);
    cur_req = "R7";                  // State3 code 6: m1 beats m3 -> State1
    hit(4'b1010);
    cur_req = "R5";                  // State1 any -> State3
    hit(4'b0001);
    cur_req = "R8";                  // m0 unnamed in code 6
    hit(4'b0001);
    cur_req = "R5";                  // m3 -> State2
    hit(4'b1000);
    cur_req = "R8";                  // State2 code 15: m0 unnamed
    hit(4'b0001);
    cur_req = "R6";                  // m3 final beats m1
    hit(4'b1010);
    cur_req = "R9";
    hit(4'b1111); hit(4'b1111);
    cur_req = "R2";                  // re-arm from Final
    pulse_arm();
    cur_req = "R3";
    arm = 1'b1; disarm = 1'b1; match = 4'hF; tick();
    arm = 1'b0; disarm = 1'b0; match = '0; tick();

    cur_req = "R4";                  // only m0 enabled
    wr(2'd3, 4'b0001);
    pulse_arm();
    hit(4'b1110);
    hit(4'b0001);
    cur_req = "R3";
    disarm = 1'b1; tick(); disarm = 1'b0;

    cur_req = "R8";                  // reserved code 0
    wr(2'd0, 4'd0); wr(2'd3, 4'hF);
    pulse_arm();
    hit(4'hF); hit(4'hF);
    disarm = 1'b1; tick(); disarm = 1'b0;

    cur_req = "R5";
    for (int i = 0; i < 6000; i++) begin
      arm    = ($urandom % 8) == 0;
      disarm = ($urandom % 64) == 0;
      match  = 4'($urandom);
      raddr  = 2'($urandom);
      we     = (m_armed == 0) ? (($urandom % 3) == 0) : (($urandom % 16) == 0);
      waddr  = 2'($urandom);
      wdata  = 4'($urandom);
      tick();
    end
    arm = 1'b0; disarm = 1'b0; match = '0; we = 1'b0;
    tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule